// File: doc/BRIEF.md
# Serial Audio Direction Control and Status Register

This block is the control and status register for one direction (transmit or receive) of a serial audio port. Software reaches it through a plain 32-bit write port with a combinational readback. The register holds a run enable, a DMA request enable, five interrupt enables and five event flags. It also carries a software-reset bit and a self-clearing FIFO-reset command.

The datapath drives pulses into the block for three events: start of word, frame-sync error, and FIFO error. A FIFO error is an underrun when the direction transmits and an overflow when it receives. The datapath also presents two live conditions, the FIFO level (empty for transmit, full for receive) and the watermark, plus a strobe that marks the end of each frame. The block drives the interrupt line, the DMA request, a one-cycle FIFO pointer reset, the effective transfer enable and the held software reset.

The run enable is aligned to frame boundaries. Setting it does not start the datapath until the next frame-end strobe. Clearing it lets the frame in progress finish, and the bit keeps reading 1 until that frame ends.

Top module: `aud_dir_csr`

## Requirements
- R1: After reset every readable bit of `rd_data` is 0, except that bit 19 and bit 20 show the live inputs. `irq`, `dma_req`, `xfer_en`, `fifo_rst` and `sw_rst` are all low.
- R2: Bits 16 (word start), 17 (sync error) and 18 (FIFO error) latch when their event pulse arrives. Each one clears only when software writes 1 to it. Writing 0 to one of these bits leaves it unchanged.
- R3: When an event pulse and a write-1-to-clear of the same flag fall in the same cycle, the flag stays set.
- R4: Bit 19 reads the live `fifo_lvl` input and bit 20 reads the live `fifo_wm` input. Writes have no effect on either bit.
- R5: The interrupt enable for flag bit 16+k is bit 8+k, for k from 0 to 4. `irq` is high exactly when at least one flag is set and its enable bit is 1.
- R6: Writing 1 to bit 25 raises `fifo_rst` for exactly one cycle, in the cycle after the write. Bit 25 always reads 0.
- R7: After a write of 1 to bit 0, bit 0 reads 1 at once. `xfer_en` rises only in the cycle after the next `frame_end` strobe.
- R8: After a write of 0 to bit 0, both bit 0 and `xfer_en` stay 1 until a `frame_end` strobe is seen, and are 0 from the following cycle.
- R9: Writing 1 to bit 24 sets `sw_rst` and clears the run, DMA, interrupt-enable and sticky flag state. While bit 24 is 1, writes change only bit 24 and events are not latched. Writing 0 to bit 24 releases the block.
- R10: `dma_req` is high exactly when the DMA enable (bit 1) is 1 and `fifo_wm` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register readback |
| ev_word | input | 1 | Start-of-word event pulse |
| ev_sync_err | input | 1 | Frame-sync error event pulse |
| ev_fifo_err | input | 1 | FIFO underrun (transmit) or overflow (receive) pulse |
| fifo_lvl | input | 1 | Live FIFO empty (transmit) or full (receive) condition |
| fifo_wm | input | 1 | Live FIFO watermark condition |
| frame_end | input | 1 | Strobe marking the last cycle of a frame |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| fifo_rst | output | 1 | One-cycle FIFO pointer reset |
| xfer_en | output | 1 | Effective, frame-aligned transfer enable |
| sw_rst | output | 1 | Software reset held to the datapath |

## Verification
The bench targets four corner cases:

- An event that coincides with its own write-1-to-clear. A design where the clear wins would lose a sync error or an underrun.
- A run enable written in the middle of a frame. A design that acts on the write at once would raise `xfer_en` before the frame boundary, or drop it before the frame has finished.
- A write of zero to a sticky flag, and a write to a live flag. A design that gets these wrong would erase pending events or latch FIFO state that should track the input.
- The software-reset write, together with the writes that follow it. A leaky hold would let fields come back before release, or would emit a FIFO reset pulse while the block is held.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;
    localparam int CSR_W     = 32;
    localparam int N_STICKY  = 3;
    localparam int N_LIVE    = 2;
    localparam int N_FLAG    = N_STICKY + N_LIVE;
    localparam int RUN_BIT   = 0;
    localparam int DMA_BIT   = 1;
    localparam int IE_LSB    = 8;
    localparam int FLAG_OFS  = 8;
    localparam int FLAG_LSB  = IE_LSB + FLAG_OFS;
    localparam int LIVE_LSB  = FLAG_LSB + N_STICKY;
    localparam int SRST_BIT  = 24;
    localparam int FRST_BIT  = 25;
endpackage

// File: rtl/aud_csr_sticky.sv
module aud_csr_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flg;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (hold) begin
            nxt_d.flg = '0;
        end else begin
            nxt_d.flg = (cur_q.flg & ~clr_i) | set_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign flag_o = cur_q.flg;

    // R3: an arriving event is never lost, even against a clear
    a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i && !hold) |=> ((flag_o & $past(set_i)) == $past(set_i)));

    // R2: a clear without a matching event empties the flag
    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flag_o & $past(clr_i & ~set_i)) == '0));

    // R2: a flag does not drop without a clear or hold
    a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && clr_i == '0) |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
endmodule

// File: rtl/aud_csr_run.sv
module aud_csr_run (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic wr,
    input  logic wr_val,
    input  logic frame_end,
    output logic req_o,
    output logic act_o
);
    typedef struct packed {
        logic req;
        logic act;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (hold) begin
            nxt_d = '0;
        end else begin
            if (wr)        nxt_d.req = wr_val;
            if (frame_end) nxt_d.act = nxt_d.req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign req_o = cur_q.req;
    assign act_o = cur_q.act;

    // R8: an active transfer runs on until a frame boundary
    a_r8_stop_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o && !frame_end && !hold) |=> act_o);

    // R7: a transfer only starts on a frame boundary
    a_r7_start_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_o && !frame_end) |=> !act_o);
endmodule

// File: rtl/aud_csr_irq.sv
module aud_csr_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] ie_i,
    output logic         irq_o
);
    logic [N-1:0] gated;

    for (genvar k = 0; k < N; k++) begin : g_gate
        assign gated[k] = flag_i[k] & ie_i[k];
    end

    assign irq_o = |gated;

    // R5: no interrupt can come out with every enable off
    a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_i == '0) |-> !irq_o);

    // R5: no interrupt without a pending flag
    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_i == '0) |-> !irq_o);
endmodule

// File: rtl/aud_dir_csr.sv
module aud_dir_csr
    import aud_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] rd_data,
    input  logic             ev_word,
    input  logic             ev_sync_err,
    input  logic             ev_fifo_err,
    input  logic             fifo_lvl,
    input  logic             fifo_wm,
    input  logic             frame_end,
    output logic             irq,
    output logic             dma_req,
    output logic             fifo_rst,
    output logic             xfer_en,
    output logic             sw_rst
);
    typedef struct packed {
        logic              dma;
        logic [N_FLAG-1:0] ie;
        logic              srst;
        logic              frst;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic                hold;
    logic                wr_ok;
    logic [N_STICKY-1:0] ev_vec;
    logic [N_STICKY-1:0] clr_vec;
    logic [N_STICKY-1:0] sticky;
    logic [N_FLAG-1:0]   all_flags;
    logic                run_req;
    logic                run_act;

    assign wr_ok  = wr_en & ~ctl_q.srst;
    assign ev_vec = {ev_fifo_err, ev_sync_err, ev_word};

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.frst = 1'b0;
        if (wr_en) ctl_d.srst = wr_data[SRST_BIT];
        if (ctl_d.srst || ctl_q.srst) begin
            ctl_d.dma = 1'b0;
            ctl_d.ie  = '0;
        end else if (wr_en) begin
            ctl_d.dma  = wr_data[DMA_BIT];
            ctl_d.ie   = wr_data[IE_LSB +: N_FLAG];
            ctl_d.frst = wr_data[FRST_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign hold    = ctl_d.srst | ctl_q.srst;
    assign clr_vec = wr_ok ? wr_data[FLAG_LSB +: N_STICKY] : '0;

    aud_csr_sticky #(.N(N_STICKY)) i_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .set_i  (ev_vec),
        .clr_i  (clr_vec),
        .flag_o (sticky)
    );

    aud_csr_run i_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .wr        (wr_ok),
        .wr_val    (wr_data[RUN_BIT]),
        .frame_end (frame_end),
        .req_o     (run_req),
        .act_o     (run_act)
    );

    assign all_flags = {fifo_wm, fifo_lvl, sticky};

    aud_csr_irq #(.N(N_FLAG)) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (all_flags),
        .ie_i   (ctl_q.ie),
        .irq_o  (irq)
    );

    always_comb begin
        rd_data                       = '0;
        rd_data[RUN_BIT]              = run_req | run_act;
        rd_data[DMA_BIT]              = ctl_q.dma;
        rd_data[IE_LSB +: N_FLAG]     = ctl_q.ie;
        rd_data[FLAG_LSB +: N_FLAG]   = all_flags;
        rd_data[SRST_BIT]             = ctl_q.srst;
    end

    assign dma_req  = ctl_q.dma & fifo_wm;
    assign fifo_rst = ctl_q.frst;
    assign xfer_en  = run_act;
    assign sw_rst   = ctl_q.srst;

    // R6: the FIFO reset pulse follows a command write and lasts one cycle
    a_r6_frst_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst |-> $past(wr_en && wr_data[FRST_BIT]));
    a_r6_frst_single: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rst && !(wr_en && wr_data[FRST_BIT])) |=> !fifo_rst);

    // R9: while held in software reset, control state stays cleared
    a_r9_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |-> (!dma_req && !xfer_en && !fifo_rst && !irq));

    // R10: a DMA request always comes with the watermark
    a_r10_dma_needs_wm: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> fifo_wm);
endmodule

// File: tb/test_aud_dir_csr.sv
`timescale 1ns/1ps
module test_aud_dir_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ev_word = 1'b0, ev_sync_err = 1'b0, ev_fifo_err = 1'b0;
    logic        fifo_lvl = 1'b0, fifo_wm = 1'b0, frame_end = 1'b0;
    logic        irq, dma_req, fifo_rst, xfer_en, sw_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model of the register
    logic       m_req, m_act, m_dma, m_srst, m_frst;
    logic [4:0] m_ie;
    logic [2:0] m_stk;

    always #4 clk = ~clk;

    aud_dir_csr i_aud_dir_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ev_word(ev_word), .ev_sync_err(ev_sync_err),
        .ev_fifo_err(ev_fifo_err), .fifo_lvl(fifo_lvl), .fifo_wm(fifo_wm),
        .frame_end(frame_end), .irq(irq), .dma_req(dma_req),
        .fifo_rst(fifo_rst), .xfer_en(xfer_en), .sw_rst(sw_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_irq();
        return |({fifo_wm, fifo_lvl, m_stk} & m_ie);
    endfunction

    task automatic model_reset();
        m_req = 0; m_act = 0; m_dma = 0; m_srst = 0; m_frst = 0;
        m_ie = '0; m_stk = '0;
    endtask

    // compares live outputs to the model, then advances the model with the clock
    task automatic step(input logic wr, input logic [31:0] wd, input logic [2:0] ev,
                        input logic lvl, input logic wm, input logic fe);
        logic nsrst;
        wr_en = wr; wr_data = wd;
        {ev_fifo_err, ev_sync_err, ev_word} = ev;
        fifo_lvl = lvl; fifo_wm = wm; frame_end = fe;
        #1;
        chk("R7 run bit", {31'd0, rd_data[0]}, {31'd0, m_req | m_act});
        chk("R10 dma bit", {31'd0, rd_data[1]}, {31'd0, m_dma});
        chk("R5 enables", {27'd0, rd_data[12:8]}, {27'd0, m_ie});
        chk("R2 sticky", {29'd0, rd_data[18:16]}, {29'd0, m_stk});
        chk("R4 live", {30'd0, rd_data[20:19]}, {30'd0, wm, lvl});
        chk("R9 srst bit", {31'd0, rd_data[24]}, {31'd0, m_srst});
        chk("R6 frst reads 0", {31'd0, rd_data[25]}, 32'd0);
        chk("R5 irq", {31'd0, irq}, {31'd0, exp_irq()});
        chk("R10 dma_req", {31'd0, dma_req}, {31'd0, m_dma & wm});
        chk("R8 xfer_en", {31'd0, xfer_en}, {31'd0, m_act});
        chk("R6 fifo_rst", {31'd0, fifo_rst}, {31'd0, m_frst});
        chk("R9 sw_rst", {31'd0, sw_rst}, {31'd0, m_srst});
        nsrst = wr ? wd[24] : m_srst;
        m_frst = 1'b0;
        if (nsrst || m_srst) begin
            m_req = 0; m_act = 0; m_dma = 0; m_ie = '0; m_stk = '0;
        end else begin
            m_stk = (m_stk & ~(wr ? wd[18:16] : 3'b000)) | ev;
            if (wr) begin
                m_req = wd[0]; m_dma = wd[1]; m_ie = wd[12:8]; m_frst = wd[25];
            end
            if (fe) m_act = m_req;
        end
        m_srst = nsrst;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_a0d1));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rd_data", rd_data, 32'd0);
        chk("R1 outputs", {27'd0, irq, dma_req, fifo_rst, xfer_en, sw_rst}, 32'd0);

        // R2: latch each event, write 0 keeps them, write 1 clears one
        step(0, 0, 3'b111, 0, 0, 0);
        step(1, 32'h0000_0000, 3'b000, 0, 0, 0);
        chk("R2 write0 keeps", {29'd0, rd_data[18:16]}, 32'd7);
        step(1, 32'h0002_0000, 3'b000, 0, 0, 0);
        chk("R2 w1c one bit", {29'd0, rd_data[18:16]}, 32'd5);

        // R3: event and clear of bit 16 together
        step(1, 32'h0001_0000, 3'b001, 0, 0, 0);
        chk("R3 event wins", {31'd0, rd_data[16]}, 32'd1);

        // R4: writing ones to live bits does nothing
        step(1, 32'h0018_0000, 3'b000, 0, 0, 0);
        chk("R4 live unwritable", {30'd0, rd_data[20:19]}, 32'd0);

        // R5: enable only the watermark interrupt
        step(1, 32'h0000_1000, 3'b000, 0, 1, 0);
        step(0, 0, 3'b000, 0, 1, 0);
        chk("R5 wm irq", {31'd0, irq}, 32'd1);

        // R7: run set mid-frame, starts after the boundary
        step(1, 32'h0000_0001, 3'b000, 0, 0, 0);
        chk("R7 reads 1 early", {31'd0, rd_data[0]}, 32'd1);
        chk("R7 not started", {31'd0, xfer_en}, 32'd0);
        step(0, 0, 3'b000, 0, 0, 1);
        chk("R7 started", {31'd0, xfer_en}, 32'd1);

        // R8: clear mid-frame keeps running
        step(1, 32'h0000_0000, 3'b000, 0, 0, 0);
        step(0, 0, 3'b000, 0, 0, 0);
        chk("R8 still running", {31'd0, rd_data[0] & xfer_en}, 32'd1);
        step(0, 0, 3'b000, 0, 0, 1);
        chk("R8 stopped", {30'd0, rd_data[0], xfer_en}, 32'd0);

        // R6: FIFO reset pulse
        step(1, 32'h0200_0000, 3'b000, 0, 0, 0);
        chk("R6 pulse", {31'd0, fifo_rst}, 32'd1);
        step(0, 0, 3'b000, 0, 0, 0);
        chk("R6 self clear", {31'd0, fifo_rst}, 32'd0);

        // R9: software reset holds and ignores other writes
        step(1, 32'h0000_1f03, 3'b000, 0, 0, 1);
        step(1, 32'h0100_0000, 3'b111, 0, 0, 0);
        step(1, 32'h0300_1f03, 3'b111, 0, 0, 1);
        chk("R9 held", {rd_data[24], rd_data[18:16], rd_data[12:8], rd_data[1:0]}, 11'h400);
        step(1, 32'h0000_0000, 3'b000, 0, 0, 0);
        chk("R9 released", {31'd0, sw_rst}, 32'd0);

        // R10: DMA request with watermark
        step(1, 32'h0000_0002, 3'b000, 0, 1, 0);
        chk("R10 dma on", {31'd0, dma_req}, 32'd1);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wd;
            logic        w;
            w  = ($urandom % 4) == 0;
            wd = $urandom;
            wd[24] = ($urandom % 16) == 0;
            step(w, wd, 3'($urandom % 8 & (($urandom % 3 == 0) ? 7 : 0)),
                 1'($urandom % 2), 1'($urandom % 2), ($urandom % 8) == 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule